// File: doc/BRIEF.md
# Peripheral Power-Up Register Loader

After a system reset this block brings an external peripheral chip into a known state. First it keeps the peripheral's reset pin active for a fixed number of clock cycles. Then it writes a fixed list of register address/data pairs to the chip over a parallel bus, one entry at a time. Each write drives an active-low strobe. A loaded down-counter sets how long the strobe stays low and how long it then stays high before the next write may begin. When the last entry has been written, a completion flag goes high and stays high.

Two clocked machines share the work. A sequencer owns the reset hold, the table index and the completion flag. A write engine owns the strobe timing and the bus registers. They talk over a four-phase request/acknowledge handshake, so the timing of one access lives in a single place and is controlled by parameters rather than by one state per cycle. The table is generated from a formula, so its size is a parameter.

Top module: `periph_init`

## Requirements
- R1: While `rst` is high at a clock edge, the block drives `per_rst_n` low, `wr_n` high, `init_done` low, and `bus_addr` and `bus_data` to zero.
- R2: After `rst` falls, `per_rst_n` stays low for exactly `HOLD_CYC` clock cycles and then goes high. No strobe occurs while `per_rst_n` is low.
- R3: Table entry i (i = 0 to `N_ENTRIES`-1) has address 3*i+1, truncated to `ADDR_W` bits, and data 16'h1000 + i*16'h0101, truncated to `DATA_W` bits. The entries are written exactly once each per initialization, in increasing i.
- R4: Each write holds `wr_n` low for exactly `LOW_CYC` consecutive cycles.
- R5: After each low phase, `wr_n` stays high for at least `HIGH_CYC` cycles before the next low phase begins.
- R6: `bus_addr` and `bus_data` carry the entry being written when `wr_n` falls. They stay unchanged from that falling edge until the high recovery phase ends.
- R7: The sequencer and the engine use a four-phase handshake. The engine raises done only while start is high. The sequencer lowers start only after done is high. The engine lowers done only after start is low.
- R8: `init_done` rises only after the last entry has completed its high recovery of at least `HIGH_CYC` cycles. It then stays high, and no further strobe occurs until the next reset.
- R9: A reset asserted during an access ends it: `wr_n` is high after the next clock edge. The next initialization repeats the full hold and restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both machines |
| rst | input | 1 | Synchronous active-high reset |
| per_rst_n | output | 1 | Active-low reset to the peripheral |
| bus_addr | output | ADDR_W | Register address bus |
| bus_data | output | DATA_W | Register data bus |
| wr_n | output | 1 | Active-low write strobe |
| init_done | output | 1 | High once every table entry has been written |

## Verification
The scoreboard measures the exact length of the reset hold. A counter off by one here would shorten or stretch the peripheral's reset. Each strobe's low width is compared against an exact count, and each high gap against a minimum. An engine that reloaded its counter wrongly would produce a 4- or 6-cycle pulse, or start the next write before recovery ends. The address and data seen at each falling edge are checked against the table in order, and the bus is checked again at each rising edge. An index bug would then show as a skipped, repeated or extra entry, and a bus that changed mid-pulse would also be caught. A reset is forced in the middle of the third write. A design that kept the old index or shortened the second hold would write the wrong entry first or release the peripheral early.

// File: rtl/pinit_pkg.sv
package pinit_pkg;

  typedef enum logic [1:0] {
    E_IDLE,
    E_LOW,
    E_HIGH,
    E_ACK
  } eng_state_t;

  typedef enum logic [1:0] {
    S_HOLD,
    S_REQ,
    S_REL,
    S_FIN
  } seq_state_t;

  // Table contents are computed, not listed.
  function automatic logic [31:0] entry_addr(input int unsigned i);
    return 32'(3 * i + 1);
  endfunction

  function automatic logic [31:0] entry_data(input int unsigned i);
    return 32'h1000 + 32'(i) * 32'h0101;
  endfunction

endpackage

// File: rtl/pinit_table.sv
module pinit_table #(
  parameter int N_ENTRIES = 10,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import pinit_pkg::*;

  logic [ADDR_W-1:0] rom_addr [N_ENTRIES];
  logic [DATA_W-1:0] rom_data [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_rom
    assign rom_addr[g] = ADDR_W'(entry_addr(g));
    assign rom_data[g] = DATA_W'(entry_data(g));
  end

  always_comb begin
    addr = '0;
    data = '0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      if (idx == IDX_W'(k)) begin
        addr = rom_addr[k];
        data = rom_data[k];
      end
    end
  end

endmodule

// File: rtl/pinit_wr_engine.sv
module pinit_wr_engine #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int LOW_CYC  = 5,
  parameter int HIGH_CYC = 8,
  localparam int MAXC    = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC,
  localparam int CNT_W   = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              done,
  output logic              wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);
  import pinit_pkg::*;

  eng_state_t       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      cnt      <= '0;
      wr_n     <= 1'b1;
      done     <= 1'b0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (start) begin
            bus_addr <= addr_in;
            bus_data <= data_in;
            wr_n     <= 1'b0;
            cnt      <= CNT_W'(LOW_CYC - 1);
            st       <= E_LOW;
          end
        end
        E_LOW: begin
          if (cnt == '0) begin
            wr_n <= 1'b1;
            cnt  <= CNT_W'(HIGH_CYC - 1);
            st   <= E_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_HIGH: begin
          if (cnt == '0) begin
            done <= 1'b1;
            st   <= E_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_ACK: begin
          if (!start) begin
            done <= 1'b0;
            st   <= E_IDLE;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pinit_seq.sv
module pinit_seq #(
  parameter int N_ENTRIES = 10,
  parameter int HOLD_CYC  = 1600000,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int HOLD_W   = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  output logic             start,
  output logic [IDX_W-1:0] idx,
  output logic             per_rst_n,
  output logic             init_done
);
  import pinit_pkg::*;

  seq_state_t        st;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HOLD;
      hold_cnt  <= '0;
      start     <= 1'b0;
      idx       <= '0;
      per_rst_n <= 1'b0;
      init_done <= 1'b0;
    end else begin
      case (st)
        S_HOLD: begin
          if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) begin
            per_rst_n <= 1'b1;
            start     <= 1'b1;
            st        <= S_REQ;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        S_REQ: begin
          if (done) begin
            start <= 1'b0;
            st    <= S_REL;
          end
        end
        S_REL: begin
          if (!done) begin
            if (idx == IDX_W'(N_ENTRIES - 1)) begin
              init_done <= 1'b1;
              st        <= S_FIN;
            end else begin
              idx   <= idx + 1'b1;
              start <= 1'b1;
              st    <= S_REQ;
            end
          end
        end
        S_FIN: st <= S_FIN;
        default: st <= S_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/periph_init.sv
module periph_init #(
  parameter int N_ENTRIES = 10,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int HOLD_CYC  = 1600000,
  parameter int LOW_CYC   = 5,
  parameter int HIGH_CYC  = 8,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              per_rst_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              wr_n,
  output logic              init_done
);

  logic              wr_start;
  logic              wr_done;
  logic [IDX_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] tbl_addr;
  logic [DATA_W-1:0] tbl_data;

  pinit_seq #(
    .N_ENTRIES(N_ENTRIES),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .done     (wr_done),
    .start    (wr_start),
    .idx      (tbl_idx),
    .per_rst_n(per_rst_n),
    .init_done(init_done)
  );

  pinit_table #(
    .N_ENTRIES(N_ENTRIES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_table (
    .idx (tbl_idx),
    .addr(tbl_addr),
    .data(tbl_data)
  );

  pinit_wr_engine #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (wr_start),
    .addr_in (tbl_addr),
    .data_in (tbl_data),
    .done    (wr_done),
    .wr_n    (wr_n),
    .bus_addr(bus_addr),
    .bus_data(bus_data)
  );

endmodule

// File: rtl/periph_init_chk.sv
module periph_init_chk #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int LOW_CYC = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              per_rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              wr_n,
  input logic              init_done,
  input logic              start,
  input logic              done
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)        low_run <= '0;
    else if (!wr_n) low_run <= low_run + 1'b1;
    else            low_run <= '0;
  end

  assert_no_strobe_in_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !per_rst_n |-> wr_n);

  assert_low_width_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (low_run < 16'(LOW_CYC)));

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

  assert_done_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> start);

  assert_start_drop_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(start) |-> done);

  assert_done_drop_after_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> !start);

  assert_init_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (wr_n && per_rst_n && !start));

endmodule

bind periph_init periph_init_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LOW_CYC(LOW_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .per_rst_n(per_rst_n),
  .bus_addr (bus_addr),
  .bus_data (bus_data),
  .wr_n     (wr_n),
  .init_done(init_done),
  .start    (wr_start),
  .done     (wr_done)
);

// File: tb/periph_init_bench.sv
module periph_init_bench;

  localparam int N  = 10;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int HOLD = 40;
  localparam int LOW  = 5;
  localparam int HIGH = 8;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          per_rst_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          wr_n;
  logic          init_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int writes_seen = 0;
  int last_rise_cyc = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  periph_init #(
    .N_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW),
    .HOLD_CYC(HOLD), .LOW_CYC(LOW), .HIGH_CYC(HIGH)
  ) u_periph_init (
    .clk(clk), .rst(rst), .per_rst_n(per_rst_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .wr_n(wr_n), .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: expected table per R3.
  task automatic push_table();
    exp_q.delete();
    for (int i = 0; i < N; i++) begin
      item_t it;
      it.a = AW'(3 * i + 1);
      it.d = DW'(32'h1000 + i * 32'h0101);
      exp_q.push_back(it);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor
  logic  prev_wr_n = 1'b1;
  bit    tracking = 1'b0;
  bit    had_rise = 1'b0;
  int    low_cnt = 0;
  int    high_cnt = 0;
  item_t cur;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      tracking = 1'b0;
      had_rise = 1'b0;
      low_cnt  = 0;
      high_cnt = 0;
    end else begin
      if (prev_wr_n && !wr_n) begin
        check(per_rst_n == 1'b1, "R2", "strobe during hold", per_rst_n, 1);
        if (had_rise)
          check(high_cnt >= HIGH, "R5", "high gap", high_cnt, HIGH);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "extra write", bus_addr, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(bus_addr == e.a, "R3", "address", bus_addr, e.a);
          check(bus_data == e.d, "R3", "data", bus_data, e.d);
          cur = e;
        end
        writes_seen++;
        tracking = 1'b1;
        low_cnt  = 1;
      end else if (!wr_n) begin
        low_cnt++;
      end else if (!prev_wr_n && wr_n && tracking) begin
        check(low_cnt == LOW, "R4", "low width", low_cnt, LOW);
        check(bus_addr == cur.a && bus_data == cur.d, "R6", "bus held",
              {bus_addr, bus_data}, {cur.a, cur.d});
        had_rise = 1'b1;
        high_cnt = 1;
        last_rise_cyc = cyc;
      end else if (wr_n) begin
        high_cnt++;
      end
    end
    prev_wr_n = wr_n;
  end

  task automatic measure_hold();
    int n = 0;
    rst = 1'b0;
    do begin
      @(negedge clk);
      n++;
    end while (!per_rst_n && n < 10 * HOLD);
    check(n == HOLD, "R2", "hold cycles", n, HOLD);
  endtask

  task automatic wait_done_and_check();
    while (!init_done) @(negedge clk);
    check(cyc - last_rise_cyc >= HIGH, "R8", "done after recovery",
          cyc - last_rise_cyc, HIGH);
    check(exp_q.size() == 0, "R3", "entries left", exp_q.size(), 0);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!init_done || !wr_n)
        check(1'b0, "R8", "done held quiet", {init_done, wr_n}, 2'b11);
    end
    check(init_done == 1'b1, "R8", "init_done held", init_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(per_rst_n == 1'b0, "R1", "per_rst_n in reset", per_rst_n, 0);
    check(wr_n == 1'b1, "R1", "wr_n in reset", wr_n, 1);
    check(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
    check(bus_addr == '0 && bus_data == '0, "R1", "bus in reset",
          {bus_addr, bus_data}, 0);

    push_table();
    measure_hold();
    wait_done_and_check();

    // Abort during the third write (R9).
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    push_table();
    writes_seen = 0;
    measure_hold();
    while (!(writes_seen == 3 && wr_n == 1'b0)) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(wr_n == 1'b1, "R9", "strobe released", wr_n, 1);
    check(per_rst_n == 1'b0, "R9", "peripheral reset again", per_rst_n, 0);
    check(init_done == 1'b0, "R9", "done cleared", init_done, 0);
    @(negedge clk);
    push_table();
    measure_hold();
    wait_done_and_check();
    check(writes_seen == 3 + N, "R9", "writes after restart", writes_seen, 3 + N);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual no completion expected completion");
    finish_run();
  end

endmodule